// File: doc/BRIEF.md
# DDR2 Burst Write Sequencer

This block sits on the controller side of a DDR2-style memory interface. It issues one burst write at a time and schedules its data phase. A host hands it a request through a valid/ready port. Each request carries a bank, a starting column, a burst-length select and up to eight data beats. The block answers with a write command on the chip-select, RAS, CAS and WE lines, with the column on the address bus. It then waits out the write latency and drives the data strobe: a low preamble, then one beat on every strobe edge, then a half-cycle postamble.

The same request port also takes single-bank precharge requests. After the last beat of a write to a bank, a write-recovery interval must pass before that bank may be precharged. A precharge that arrives too early is held off with ready low. Precharges to other banks are not delayed.

Each clock cycle is split into two half-cycle slots. The strobe level, the strobe enable, the data enable and the data beat are each given per slot: one output for the first half of the cycle and one for the second.

Top module: `ddr2_burst_writer`

## Requirements
- R1: One cycle after a write request is accepted, the command bus carries the write encoding (cs_n=0, ras_n=1, cas_n=0, we_n=0) for exactly one cycle, with ba set to the request bank and addr set to the zero-extended column.
- R2: One cycle after a precharge request is accepted, the command bus carries the precharge encoding (cs_n=0, ras_n=0, cas_n=1, we_n=0) for one cycle, with ba set to the request bank and addr all zero, so that the all-banks bit addr[10] is low.
- R3: In every cycle with no command, the bus carries NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) with ba and addr zero. This includes cycles where req_valid is low and the other request inputs are arbitrary.
- R4: The first data cycle comes exactly WL = AL + CL - 1 cycles after the write command cycle. With AL=2 and CL=3 this is 4 cycles.
- R5: In the cycle just before the first data cycle (the preamble), dqs_oe is 2'b11 and dqs is 2'b00, and dq_oe is 2'b00.
- R6: During each data cycle, dqs is 2'b01, meaning high in the first half-cycle and low in the second (bit 0 is the first half). dqs_oe and dq_oe are both 2'b11. Data cycle i drives beat 2i on dq_rise and beat 2i+1 on dq_fall, where beat k is req_data[k*DQ_W +: DQ_W].
- R7: In the cycle after the last data cycle (the postamble), dqs_oe is 2'b01 and dqs is 2'b00. The strobe is enabled for the first half-cycle only.
- R8: req_bl8=1 gives four data cycles (8 beats) and req_bl8=0 gives two (4 beats). With 4 beats, beats 4 to 7 of req_data never appear. Outside the preamble, data and postamble cycles, dqs, dqs_oe, dq_oe, dq_rise and dq_fall are all zero.
- R9: Once a write is accepted, req_ready stays low for every request up to and including its postamble cycle.
- R10: A bank whose last data cycle was L cannot be precharged early. req_ready is low for a precharge to that bank in every cycle before L+TWR, and its precharge command never appears before cycle L+TWR+1.
- R11: A precharge to a bank with no pending write recovery is accepted as soon as no burst is in progress, even while another bank is still in recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid is also high |
| req_pre | input | 1 | 1 = precharge request, 0 = burst write |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Starting column of the write |
| req_bl8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| req_data | input | 8*DQ_W | Write beats, beat k at bits k*DQ_W |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Address bus |
| dqs | output | 2 | Strobe level per half-cycle (bit 0 first half) |
| dqs_oe | output | 2 | Strobe output enable per half-cycle |
| dq_oe | output | 2 | Data output enable per half-cycle |
| dq_rise | output | DQ_W | Beat launched on the rising strobe edge |
| dq_fall | output | DQ_W | Beat launched on the falling strobe edge |

## Verification
The hardest case to reach is a precharge that arrives while its bank is still in write recovery but no burst is running. Only then is the recovery counter, and not the busy flag, the thing that holds ready low. To get there, the bench issues a burst write and holds a precharge to the same bank valid from the very next cycle, so the stall lasts through the whole burst and then through the recovery window.

A second burst goes to another bank. Its precharge is retargeted partway through the stall to an idle bank, which must be accepted at once. The bank in recovery must still wait.

Four-beat bursts carry nonzero data in the unused upper beats, so any leak of those beats onto the data lines is seen.

// File: rtl/ddr2_burst_writer.sv
module ddr2_burst_writer #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 14,
  parameter int DQ_W   = 8,
  parameter int AL     = 2,
  parameter int CL     = 3,
  parameter int TWR    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_pre,
  input  logic [BANK_W-1:0]   req_bank,
  input  logic [COL_W-1:0]    req_col,
  input  logic                req_bl8,
  input  logic [8*DQ_W-1:0]   req_data,
  output logic                cs_n,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [BANK_W-1:0]   ba,
  output logic [ADDR_W-1:0]   addr,
  output logic [1:0]          dqs,
  output logic [1:0]          dqs_oe,
  output logic [1:0]          dq_oe,
  output logic [DQ_W-1:0]     dq_rise,
  output logic [DQ_W-1:0]     dq_fall
);

  localparam int WL    = AL + CL - 1;
  localparam int NBANK = 1 << BANK_W;
  localparam int PH_W  = $clog2(WL + 6);
  localparam int RC_W  = $clog2(TWR + 1);
  localparam logic [PH_W-1:0] PH_PRE  = PH_W'(WL - 1);
  localparam logic [PH_W-1:0] PH_D0   = PH_W'(WL);
  localparam logic [PH_W-1:0] PH_END4 = PH_W'(WL + 2);
  localparam logic [PH_W-1:0] PH_END8 = PH_W'(WL + 4);
  localparam logic [RC_W-1:0] RC_LOAD = RC_W'(TWR - 1);

  logic                busy;
  logic [PH_W-1:0]     ph;
  logic                bl8_q;
  logic [BANK_W-1:0]   bank_q;
  logic [8*DQ_W-1:0]   data_q;
  logic [NBANK-1:0]    rec_zero;
  logic [DQ_W-1:0]     beat [8];

  wire accept = req_valid && req_ready;
  wire [PH_W-1:0] ph_post = bl8_q ? PH_END8 : PH_END4;
  wire in_pre    = busy && (ph == PH_PRE);
  wire in_data   = busy && (ph >= PH_D0) && (ph < ph_post);
  wire in_post   = busy && (ph == ph_post);
  wire last_beat = in_data && (ph == ph_post - PH_W'(1));
  wire [PH_W-1:0] rel = ph - PH_D0;

  assign req_ready = rst_n && !busy && (!req_pre || rec_zero[req_bank]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      ph     <= '0;
      bl8_q  <= 1'b0;
      bank_q <= '0;
      data_q <= '0;
    end else if (accept && !req_pre) begin
      busy   <= 1'b1;
      ph     <= '0;
      bl8_q  <= req_bl8;
      bank_q <= req_bank;
      data_q <= req_data;
    end else if (busy) begin
      if (in_post) busy <= 1'b0;
      else         ph   <= ph + PH_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b0111;
      ba   <= '0;
      addr <= '0;
    end else if (accept) begin
      {cs_n, ras_n, cas_n, we_n} <= req_pre ? 4'b0010 : 4'b0100;
      ba   <= req_bank;
      addr <= req_pre ? '0 : ADDR_W'(req_col);
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b0111;
      ba   <= '0;
      addr <= '0;
    end
  end

  for (genvar k = 0; k < 8; k++) begin : g_beat
    assign beat[k] = data_q[k*DQ_W +: DQ_W];
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [RC_W-1:0] rec_cnt;
    always_ff @(posedge clk) begin
      if (!rst_n)
        rec_cnt <= '0;
      else if (last_beat && bank_q == BANK_W'(b))
        rec_cnt <= RC_LOAD;
      else if (rec_cnt != '0)
        rec_cnt <= rec_cnt - RC_W'(1);
    end
    assign rec_zero[b] = (rec_cnt == '0);
  end

  assign dqs     = in_data ? 2'b01 : 2'b00;
  assign dqs_oe  = (in_pre || in_data) ? 2'b11 : (in_post ? 2'b01 : 2'b00);
  assign dq_oe   = in_data ? 2'b11 : 2'b00;
  assign dq_rise = in_data ? beat[{rel[1:0], 1'b0}] : '0;
  assign dq_fall = in_data ? beat[{rel[1:0], 1'b1}] : '0;

  AST_CMD_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept) |-> (!cs_n && (!ras_n || !cas_n))); // R1
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept && !req_pre) |-> !req_ready); // R9
  AST_DQ_UNDER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe != 2'b00) |-> (dqs_oe == 2'b11 && dqs == 2'b01)); // R6
  AST_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe[0]) |-> ($past(dqs_oe) == 2'b11 && $past(dq_oe) == 2'b00)); // R5
  AST_POSTAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe[1]) |-> (dqs_oe == 2'b01 && dqs == 2'b00)); // R7
  AST_NO_PRE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && cas_n && !we_n) |-> (dqs_oe == 2'b00)); // R10

endmodule

// File: tb/ddr2_burst_writer_test.sv
`timescale 1ns/100ps
module ddr2_burst_writer_test;
  localparam int WL  = 2 + 3 - 1;
  localparam int TWR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_pre = 1'b0, req_bl8 = 1'b0;
  logic [1:0] req_bank = '0;
  logic [9:0] req_col = '0;
  logic [63:0] req_data = '0;
  logic req_ready, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba, dqs, dqs_oe, dq_oe;
  logic [13:0] addr;
  logic [7:0] dq_rise, dq_fall;

  always #2.5 clk = ~clk;

  ddr2_burst_writer #(.BANK_W(2), .COL_W(10), .ADDR_W(14), .DQ_W(8),
                      .AL(2), .CL(3), .TWR(TWR)) uut (
    .clk, .rst_n, .req_valid, .req_ready, .req_pre, .req_bank, .req_col,
    .req_bl8, .req_data, .cs_n, .ras_n, .cas_n, .we_n, .ba, .addr,
    .dqs, .dqs_oe, .dq_oe, .dq_rise, .dq_fall);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vecs = 0, errs = 0;
  bit done = 0;
  int busy_end = -1;
  int last_wr [4] = '{-100, -100, -100, -100};

  logic [3:0]  e_cmd [int];
  logic [1:0]  e_ba [int];
  logic [13:0] e_addr [int];
  string       e_ctag [int];
  logic [1:0]  e_dqs [int], e_dqsoe [int], e_dqoe [int];
  logic [7:0]  e_d0 [int], e_d1 [int];
  string       e_stag [int];

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic check_outputs(input int t);
    logic [3:0] c; logic [1:0] b; logic [13:0] a; string tg;
    c = e_cmd.exists(t) ? e_cmd[t] : 4'b0111;
    b = e_ba.exists(t) ? e_ba[t] : 2'b00;
    a = e_addr.exists(t) ? e_addr[t] : 14'd0;
    tg = e_ctag.exists(t) ? e_ctag[t] : "R3";
    check(tg, "cmd/ba/addr", {44'd0, cs_n, ras_n, cas_n, we_n, ba, addr}, {44'd0, c, b, a});
    if ({cs_n, ras_n, cas_n, we_n} == 4'b0010)
      check("R10", "precharge after recovery", 64'(t >= last_wr[ba] + TWR + 1), 64'd1);
    if (e_stag.exists(t))
      check(e_stag[t], "strobe/data", {28'd0, dqs, dqs_oe, dq_oe, dq_rise, dq_fall},
            {28'd0, e_dqs[t], e_dqsoe[t], e_dqoe[t], e_d0[t], e_d1[t]});
    else
      check("R8", "idle strobe/data", {28'd0, dqs, dqs_oe, dq_oe, dq_rise, dq_fall}, 64'd0);
  endtask

  task automatic step(input logic v, input logic k, input logic [1:0] b, input logic [9:0] col,
                      input logic b8, input logic [63:0] d, output logic acc);
    int t, nb, c0; logic er; string tg;
    @(negedge clk);
    req_valid = v; req_pre = k; req_bank = b; req_col = col; req_bl8 = b8; req_data = d;
    #1;
    t = cyc;
    check_outputs(t);
    er = (t > busy_end) && (!k || t >= last_wr[b] + TWR);
    if (t <= busy_end) tg = "R9";
    else if (k && t < last_wr[b] + TWR) tg = "R10";
    else if (k) tg = "R11";
    else tg = "R9";
    check(tg, "req_ready", 64'(req_ready), 64'(er));
    acc = v && er;
    if (acc) begin
      c0 = t + 1;
      e_cmd[c0] = k ? 4'b0010 : 4'b0100;
      e_ba[c0] = b;
      e_addr[c0] = k ? 14'd0 : {4'd0, col};
      e_ctag[c0] = k ? "R2" : "R1";
      if (!k) begin
        nb = b8 ? 4 : 2;
        e_dqs[c0+WL-1] = 2'b00; e_dqsoe[c0+WL-1] = 2'b11; e_dqoe[c0+WL-1] = 2'b00;
        e_d0[c0+WL-1] = 8'd0; e_d1[c0+WL-1] = 8'd0; e_stag[c0+WL-1] = "R5";
        for (int i = 0; i < nb; i++) begin
          e_dqs[c0+WL+i] = 2'b01; e_dqsoe[c0+WL+i] = 2'b11; e_dqoe[c0+WL+i] = 2'b11;
          e_d0[c0+WL+i] = d[16*i +: 8]; e_d1[c0+WL+i] = d[16*i+8 +: 8];
          e_stag[c0+WL+i] = (i == 0) ? "R4" : "R6";
        end
        e_dqs[c0+WL+nb] = 2'b00; e_dqsoe[c0+WL+nb] = 2'b01; e_dqoe[c0+WL+nb] = 2'b00;
        e_d0[c0+WL+nb] = 8'd0; e_d1[c0+WL+nb] = 8'd0; e_stag[c0+WL+nb] = "R7";
        busy_end = c0 + WL + nb;
        last_wr[b] = c0 + WL + nb - 1;
      end
    end
  endtask

  task automatic send(input logic k, input logic [1:0] b, input logic [9:0] col,
                      input logic b8, input logic [63:0] d, input int max_wait);
    logic a = 1'b0;
    for (int n = 0; n < max_wait && !a; n++) step(1'b1, k, b, col, b8, d, a);
    if (!a) check(k ? "R10" : "R9", "request never accepted", 64'd0, 64'd1);
  endtask

  task automatic idle(input int n);
    logic a;
    for (int i = 0; i < n; i++) step(1'b0, i[0], 2'(i), 10'(i * 37), i[1], 64'hDEAD_BEEF_0BAD_F00D, a);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    logic a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    send(1'b0, 2'd1, 10'h155, 1'b0, 64'hF7E6_D5C4_0403_0201, 5);
    send(1'b1, 2'd1, 10'h000, 1'b0, 64'd0, 30);
    idle(3);
    send(1'b0, 2'd2, 10'h3FF, 1'b1, 64'h8877_6655_4433_2211, 5);
    for (int i = 0; i < 9; i++) step(1'b1, 1'b1, 2'd2, 10'h0, 1'b0, 64'd0, a);
    send(1'b1, 2'd0, 10'h0, 1'b0, 64'd0, 5);
    send(1'b1, 2'd2, 10'h0, 1'b0, 64'd0, 30);
    idle(2);
    send(1'b0, 2'd3, 10'h0A5, 1'b1, 64'h0F1E_2D3C_4B5A_6978, 5);
    send(1'b0, 2'd0, 10'h2C3, 1'b0, 64'hAAAA_BBBB_1357_9BDF, 30);
    send(1'b1, 2'd3, 10'h0, 1'b0, 64'd0, 30);
    send(1'b1, 2'd0, 10'h0, 1'b0, 64'd0, 30);
    idle(15);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule